// File: doc/BRIEF.md
# Maskable Periodic Timer Interrupt

This block divides the system clock into a steady stream of timer ticks and turns each tick into a fast-interrupt request for the CPU. Every tick sets a pending flag. The interrupt line is driven while that flag is set and the timer interrupt is not prohibited. The divider period is taken from a port, so the surrounding logic can retune it without a rebuild.

Software reaches the block through a small byte-wide I/O decode. A status location reports the pending flag in bit 7. An ordinary read of that location also acknowledges the tick and drops the line. A debugger may instead make a side-effect-free read, which returns the same byte and changes nothing. A write-only mask location uses its bit 7 to prohibit the interrupt. Setting the mask silences the line on the next clock even while a tick is still pending.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask is clear, no tick is pending, `firq` is 0 and a status read returns 0x00.
- R2: With `tick_period` = P, a tick occurs every P+1 clock cycles. After reset is released, `firq` first goes high after edge P+1 and next after edge 2P+2, provided the first tick was acknowledged in between. With P = 0 a tick occurs every cycle.
- R3: A read (`io_rd`=1) at the status address 0xCA returns the pending flag in bit 7 and zeros in bits 6..0. `io_rdata` is 0x00 whenever no read is in progress.
- R4: A normal status read (`io_dbg`=0) clears the pending flag at the clock edge that ends it, and `firq` is 0 after that edge.
- R5: A status read with `io_dbg`=1 returns the same data but leaves the pending flag and `firq` unchanged.
- R6: A write to the mask address 0xD4 with bit 7 = 1 forces `firq` to 0 from the next edge on. The pending flag stays readable through the status register.
- R7: A write of bit 7 = 0 to the mask address re-enables the line, so a tick that is still pending drives `firq` again after that edge.
- R8: When a tick and a normal status read fall in the same cycle, the tick wins and the pending flag stays set.
- R9: Only bit 7 of a mask write has an effect. Writes to any address other than 0xD4 leave the mask unchanged.
- R10: The mask location is write-only: a read at 0xD4 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_period | input | CNT_W | Divider setting P; one tick per P+1 cycles |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, acted on at the clock edge |
| io_rd | input | 1 | Read strobe; data is combinational, any acknowledge happens at the edge |
| io_dbg | input | 1 | Marks a read as side-effect free |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| firq | output | 1 | Fast interrupt request, active high |

## Verification
The divider is swept over seven period settings, from every-cycle ticking up to six idle cycles. For each setting the bench measures both the first tick after reset and the spacing to the second, which separates off-by-one errors in the count limit from errors in the wrap. Status reads are tried in their normal and debug forms while a tick is pending, and the stimulus is arranged so that only a read that wrongly acknowledges would change the result. Mask writes use the values 0x80, 0x00 and 0x7F, plus a write of 0x80 to a neighbouring address, which tells apart a decode of bit 7 from a decode of the whole byte or of the wrong location. One acknowledge is timed onto the exact cycle of a tick to confirm that the tick takes priority.

// File: rtl/tick_irq_pkg.sv
// Shared constants for the maskable periodic timer interrupt.
package tick_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int FLAG_BIT = 7;  // bit carrying pending flag and mask
endpackage

// File: rtl/tick_divider.sv
// Free-running tick divider.
// Emits a one-cycle tick when the count reaches the programmed limit, then
// restarts from zero. Assumes the limit may change at any time; a count
// already past a lowered limit ticks at once and wraps.
module tick_divider #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] count;

    // Tick whenever the count has reached the limit.
    assign tick = (count >= limit);

    // Advance the count, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tick_io_decode.sv
// Register decode for the timer interrupt.
// Turns the I/O strobes into an acknowledge, a mask write and a status
// read select. Assumes a single access per cycle.
module tick_io_decode #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hCA,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'hD4
) (
    input  logic [ADDR_W-1:0]                io_addr,
    input  logic                             io_wr,
    input  logic                             io_rd,
    input  logic                             io_dbg,
    input  logic [tick_irq_pkg::DATA_W-1:0]  io_wdata,
    output logic                             status_sel,
    output logic                             ack,
    output logic                             mask_we,
    output logic                             mask_d
);
    import tick_irq_pkg::*;

    // Classify the current access.
    always_comb begin
        status_sel = io_rd && (io_addr == STATUS_ADDR);
        ack        = status_sel && !io_dbg;
        mask_we    = io_wr && (io_addr == MASK_ADDR);
        mask_d     = io_wdata[FLAG_BIT];
    end
endmodule

// File: rtl/tick_pending.sv
// Pending flag, mask bit and interrupt line.
// A tick sets the flag and takes priority over an acknowledge in the same
// cycle. The line is the flag gated by the inverted mask.
module tick_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    input  logic mask_we,
    input  logic mask_d,
    output logic pending,
    output logic masked,
    output logic firq
);
    // Set on tick, clear on acknowledge; tick wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (tick) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    // Hold the prohibit bit from mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked <= 1'b0;
        end else if (mask_we) begin
            masked <= mask_d;
        end
    end

    // Drive the request while pending and not prohibited.
    assign firq = pending && !masked;
endmodule

// File: rtl/tick_irq_ctrl.sv
// Maskable periodic timer interrupt, top level.
// Ties the divider, decode and pending logic together and forms the read
// data. Assumes io_rdata is sampled combinationally during the read cycle.
module tick_irq_ctrl #(
    parameter int                ADDR_W      = 8,
    parameter int                CNT_W       = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hCA,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'hD4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tick_period,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_dbg,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              firq
);
    import tick_irq_pkg::*;

    logic tick;
    logic status_sel;
    logic ack;
    logic mask_we;
    logic mask_d;
    logic pending;
    logic masked;

    tick_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (tick_period),
        .tick  (tick)
    );

    tick_io_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .MASK_ADDR   (MASK_ADDR)
    ) u_dec (
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_dbg     (io_dbg),
        .io_wdata   (io_wdata),
        .status_sel (status_sel),
        .ack        (ack),
        .mask_we    (mask_we),
        .mask_d     (mask_d)
    );

    tick_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ack     (ack),
        .mask_we (mask_we),
        .mask_d  (mask_d),
        .pending (pending),
        .masked  (masked),
        .firq    (firq)
    );

    // Return the pending flag in the flag bit on a status read only.
    always_comb begin
        io_rdata = '0;
        if (status_sel) begin
            io_rdata[FLAG_BIT] = pending;
        end
    end
endmodule

// File: rtl/tick_irq_ctrl_chk.sv
// Assertion checker for the timer interrupt, bound into the top level.
module tick_irq_ctrl_chk #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hCA,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'hD4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic              io_dbg,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              firq,
    input logic              tick,
    input logic              pending
);
    // R3: low bits of read data are always zero
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[6:0] == 7'd0);

    // R4: an acknowledge without a coinciding tick drops the line
    a_r4_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_dbg && io_addr == STATUS_ADDR && !tick) |=> !firq);

    // R5: a debug read keeps a raised line raised
    a_r5_debug_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_dbg && io_addr == STATUS_ADDR && firq && !io_wr) |=> firq);

    // R6: setting the mask silences the line on the next edge
    a_r6_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == MASK_ADDR && io_wdata[7]) |=> !firq);

    // R8: a tick always leaves the flag set, whatever the access
    a_r8_tick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pending);

    // R2: the flag only rises as a result of a tick
    a_r2_rise_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(tick));
endmodule

bind tick_irq_ctrl tick_irq_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .MASK_ADDR   (MASK_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_dbg   (io_dbg),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .firq     (firq),
    .tick     (tick),
    .pending  (pending)
);

// File: tb/tick_irq_ctrl_bench.sv
`timescale 1ns/1ps
module tick_irq_ctrl_bench;
    localparam logic [7:0] STAT = 8'hCA;
    localparam logic [7:0] MSK  = 8'hD4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tick_period = 8'd3;
    logic [7:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic       io_dbg = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       firq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tick_irq_ctrl u_tick_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_period(tick_period),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_dbg(io_dbg),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .firq(firq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        io_rd = 1'b0; io_wr = 1'b0; io_dbg = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] p);
        @(negedge clk);
        idle();
        tick_period = p;
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    // Read at an address across one edge; returns the data seen before it.
    task automatic rd(input logic [7:0] a, input bit dbg, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1; io_dbg = dbg;
        #1 d = io_rdata;
        cyc();
        idle();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        io_addr = a; io_wr = 1'b1; io_wdata = v;
        cyc();
        idle();
    endtask

    initial begin
        #500us;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int first;
        int gap;

        // R1: reset state
        do_reset(8'd3);
        check(firq == 1'b0, "R1", "firq after reset", firq, 0);
        io_addr = STAT; io_rd = 1'b1; io_dbg = 1'b1;
        #1 check(io_rdata == 8'h00, "R1", "status after reset", io_rdata, 0);
        idle();
        #1 check(io_rdata == 8'h00, "R3", "rdata idle", io_rdata, 0);

        // R2 sweep: first tick at edge P+1, second at 2P+2
        for (int p = 1; p <= 6; p++) begin
            do_reset(p[7:0]);
            first = 0;
            for (int k = 1; k <= 40 && first == 0; k++) begin
                cyc();
                if (firq) first = k;
            end
            check(first == p + 1, "R2", "first tick edge", first, p + 1);
            rd(STAT, 1'b0, d);
            check(d == 8'h80, "R3", "status with tick pending", d, 8'h80);
            check(firq == 1'b0, "R4", "firq after ack", firq, 0);
            gap = 0;
            for (int j = 1; j <= 40 && gap == 0; j++) begin
                cyc();
                if (firq) gap = j;
            end
            // ack edge was P+2, next rise at 2P+2
            check(gap == p, "R2", "second tick spacing", gap, p);
        end

        // R5: debug read does not acknowledge
        do_reset(8'd4);
        repeat (5) cyc();
        check(firq == 1'b1, "R2", "tick at edge 5", firq, 1);
        rd(STAT, 1'b1, d);
        check(d == 8'h80, "R5", "debug read data", d, 8'h80);
        check(firq == 1'b1, "R5", "firq after debug read", firq, 1);

        // R6: mask forces line low, flag still visible
        wr(MSK, 8'h80);
        check(firq == 1'b0, "R6", "firq when masked", firq, 0);
        io_addr = STAT; io_rd = 1'b1; io_dbg = 1'b1;
        #1 check(io_rdata == 8'h80, "R6", "pending under mask", io_rdata, 8'h80);
        io_addr = MSK;
        #1 check(io_rdata == 8'h00, "R10", "mask read back", io_rdata, 0);
        idle();

        // R7: unmask restores line
        wr(MSK, 8'h00);
        check(firq == 1'b1, "R7", "firq after unmask", firq, 1);

        // R9: only bit 7 and only the mask address count
        wr(MSK, 8'h7F);
        check(firq == 1'b1, "R9", "firq after 0x7F mask write", firq, 1);
        wr(8'hD5, 8'h80);
        check(firq == 1'b1, "R9", "firq after write elsewhere", firq, 1);

        // R8: every-cycle ticking beats acknowledge
        do_reset(8'd0);
        cyc();
        check(firq == 1'b1, "R2", "P=0 tick at edge 1", firq, 1);
        for (int i = 0; i < 3; i++) begin
            rd(STAT, 1'b0, d);
            check(firq == 1'b1, "R8", "P=0 ack loses to tick", firq, 1);
        end

        // R8: acknowledge landing on the tick edge (P=3, tick edge 8)
        do_reset(8'd3);
        repeat (4) cyc();
        rd(STAT, 1'b0, d);          // edge 5 clears
        check(firq == 1'b0, "R4", "ack at edge 5", firq, 0);
        repeat (2) cyc();           // edges 6,7
        rd(STAT, 1'b0, d);          // edge 8 coincides with tick
        check(firq == 1'b1, "R8", "ack on tick edge", firq, 1);
        rd(STAT, 1'b0, d);          // edge 9 clears
        check(firq == 1'b0, "R4", "ack after tick edge", firq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule